// File: doc/BRIEF.md
# Parallel Port with Handshake Control

This block is an 8-bit general-purpose parallel port that sits on a simple synchronous register bus. Every data pin has its own direction bit, so a single port can mix driven outputs and sampled inputs. Two control lines accompany the data. The strobe input (control line 1) raises an interrupt flag on its selected edge and, when capture is enabled, freezes the input pins into a holding register at that same edge. The second control line can work as a second interrupt input, as an automatic handshake output that answers data-register accesses, or as a plain static level.

Software programs the port through five registers: the data register, the direction mask, a control register, an interrupt flag register and an interrupt enable register. Any access to the data register clears both interrupt flags. In handshake mode, the same access pulls control line 2 low for the attached device. The line stays low until the device strobes back on control line 1 (interlocked form) or for exactly one clock (pulse form). The interrupt output is the OR of every flag that is enabled.

Top module: `hsk_pport`

## Requirements
- R1: After reset the data, direction, control, flag and enable registers read 0. `pad_oe` is 0, `irq` is 0, `ctl2_oe` is 0 and `ctl2_out` is 1.
- R2: `pad_out` follows the value last written at address 0. `pad_oe` follows the value last written at address 1, where bit 1 means output. Both change on the clock edge of the write.
- R3: A read at address 0 returns, per bit, the data register where the direction bit is 1, and the input view where it is 0. The input view is the live `pad_in` when control bit 1 is 0.
- R4: Control bit 0 picks the active edge of `ctl1_in` (1 rising, 0 falling). An active edge sets flag bit 0 on that clock edge. The opposite edge does nothing.
- R5: When control bit 1 is 1, every active edge of `ctl1_in` copies `pad_in` into a capture register. Input-direction bits read at address 0 then return that captured value and not the live pins.
- R6: Control bits 4:3 choose the line-2 mode: 00 input, 01 interlocked handshake, 10 pulse handshake, 11 static level. In input mode, control bit 2 picks the active edge of `ctl2_in` (1 rising), and an active edge sets flag bit 1.
- R7: A read or write at address 0 clears both flags. An edge arriving in that same cycle still sets its flag.
- R8: Writing the flag register (address 3) clears each flag whose write bit is 1. Bits written 0 leave their flag unchanged.
- R9: `irq` is 1 exactly when some flag bit and the matching bit of the enable register (address 4, bits 1:0) are both 1.
- R10: In interlocked mode, an access at address 0 drives `ctl2_out` low from the next cycle on. It returns high after the next active edge of `ctl1_in`.
- R11: In pulse mode, an access at address 0 drives `ctl2_out` low for exactly one cycle.
- R12: In static-level mode, `ctl2_out` equals control bit 2 and ignores data-register accesses. `ctl2_oe` is 1 in every mode except input mode.
- R13: Edges on `ctl2_in` set no flag while line 2 is in any mode other than input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register bus select |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 8 | Sampled pin levels |
| pad_out | output | 8 | Output data to pins |
| pad_oe | output | 8 | Per-pin output enable |
| ctl1_in | input | 1 | Control line 1 (strobe input) |
| ctl2_in | input | 1 | Control line 2 pin level |
| ctl2_out | output | 1 | Control line 2 driven value |
| ctl2_oe | output | 1 | Control line 2 output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a flag clear from a data-register access and a fresh control-line edge landing in the same clock cycle. The set must win there. The bench reaches it by toggling `ctl2_in` in the exact cycle that carries the data write, then reading the flag register back. A second awkward case is capture mode: live and captured input values must differ. To get there, the pins are changed after the strobe edge, before the read. Handshake timing is observed one cycle at a time after each access, including a strobe edge of the wrong polarity that must leave the line low.

// File: rtl/pport_pkg.sv
// Package: shared constants and types for the handshake parallel port.
// Assumes an 8-bit-or-wider data path so every register fits the bus.
package pport_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CTRL_W = 5;
    localparam int unsigned NFLAG  = 2;
    localparam int unsigned FLG_C1 = 0;
    localparam int unsigned FLG_C2 = 1;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;

    typedef enum logic [1:0] {
        C2_INPUT    = 2'b00,
        C2_HS_LOCK  = 2'b01,
        C2_HS_PULSE = 2'b10,
        C2_LEVEL    = 2'b11
    } c2_mode_e;

    // Control register layout, MSB first: mode[4:3], pol/level[2], latch[1], c1 rise[0]
    typedef struct packed {
        c2_mode_e c2_mode;
        logic     c2_pol;
        logic     c1_latch;
        logic     c1_rise;
    } ctrl_t;

endpackage

// File: rtl/pport_edge.sv
// Edge detector: flags the selected transition of a single control input.
// Assumes the input is already synchronous to clk. The history register
// has no reset, so it tracks the pin during reset and no false edge
// appears when reset is released.
module pport_edge (
    input  logic clk,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);

    logic prev_q;

    // Remember the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    // A transition toward the selected level is an active edge.
    always_comb begin
        hit = (pin != prev_q) && (pin == rise_sel);
    end

endmodule

// File: rtl/pport_irq.sv
// Interrupt flags: sticky per-source flags with clear-on-access and
// write-one-to-clear, plus an enable-gated request output.
// Assumes set has priority over any clear in the same cycle.
module pport_irq #(
    parameter int unsigned NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          clr_all,
    input  logic [NF-1:0] clr_mask,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic flag_q;

        // Hold one source flag; a new event beats any clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set[i]) begin
                flag_q <= 1'b1;
            end else if (clr_all || clr_mask[i]) begin
                flag_q <= 1'b0;
            end
        end

        assign flags[i] = flag_q;

        // R8: a clear flag with no event stays clear, whatever is written.
        assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q && !set[i]) |=> !flag_q);

        // R7: a data access with no event leaves this flag clear.
        assert_acc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_all && !set[i]) |=> !flag_q);
    end

    // Request whenever any enabled flag is pending.
    always_comb begin
        irq = |(flags & en);
    end

endmodule

// File: rtl/pport_ctl2.sv
// Control line 2 driver: generates the interlocked or single-cycle
// handshake after data-register accesses, or a programmed static level.
// Assumes data_acc and c1_hit are single-cycle qualified strobes.
module pport_ctl2
    import pport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  c2_mode_e mode,
    input  logic     level,
    input  logic     data_acc,
    input  logic     c1_hit,
    output logic     c2_out,
    output logic     c2_oe
);

    logic hs_q;

    // Handshake level: low after an access, released per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1;
        end else begin
            case (mode)
                C2_HS_LOCK: begin
                    if (data_acc) begin
                        hs_q <= 1'b0;
                    end else if (c1_hit) begin
                        hs_q <= 1'b1;
                    end
                end
                C2_HS_PULSE: hs_q <= !data_acc;
                default:     hs_q <= 1'b1;
            endcase
        end
    end

    // Pick the driven value and enable from the mode.
    always_comb begin
        c2_out = (mode == C2_LEVEL) ? level : hs_q;
        c2_oe  = (mode != C2_INPUT);
    end

    // R10: an access in a handshake mode drops the line on the next cycle.
    assert_hs_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode == C2_HS_LOCK) || (mode == C2_HS_PULSE)) && data_acc) |=> !hs_q);

    // R11: in pulse form a low line with no new access recovers at once.
    assert_pulse_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == C2_HS_PULSE) && !hs_q && !data_acc) |=> hs_q);

endmodule

// File: rtl/hsk_pport.sv
// Top: register decode, data/direction storage, strobe capture and read
// view of the handshake parallel port. Read data is combinational from
// the address; read side effects take place on the edge that ends a cycle
// with bus_re set. Assumes WIDTH >= 8.
module hsk_pport
    import pport_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic              ctl1_in,
    input  logic              ctl2_in,
    output logic              ctl2_out,
    output logic              ctl2_oe,
    output logic              irq
);

    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] in_view;
    ctrl_t            ctrl_q;
    logic [NFLAG-1:0] ien_q;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_w1c;
    logic             wr_en;
    logic             data_acc;
    logic             c1_hit;
    logic             c2_hit;

    // Decode bus strobes into write enable and data-register access.
    always_comb begin
        wr_en    = bus_cs && bus_we;
        data_acc = bus_cs && (bus_we || bus_re) && (bus_addr == A_DATA);
        flag_w1c = (wr_en && bus_addr == A_FLAG) ? bus_wdata[NFLAG-1:0] : '0;
    end

    // Software-visible configuration and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_DATA:  out_q  <= bus_wdata;
                A_DIR:   dir_q  <= bus_wdata;
                A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_IEN:   ien_q  <= bus_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    pport_edge i_edge_c1 (
        .clk      (clk),
        .pin      (ctl1_in),
        .rise_sel (ctrl_q.c1_rise),
        .hit      (c1_hit)
    );

    pport_edge i_edge_c2 (
        .clk      (clk),
        .pin      (ctl2_in),
        .rise_sel (ctrl_q.c2_pol),
        .hit      (c2_hit)
    );

    // Freeze the pins on an active strobe edge while capture is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (ctrl_q.c1_latch && c1_hit) begin
            cap_q <= pad_in;
        end
    end

    // Flag sources: line 2 only counts as an input in input mode.
    always_comb begin
        flag_set         = '0;
        flag_set[FLG_C1] = c1_hit;
        flag_set[FLG_C2] = c2_hit && (ctrl_q.c2_mode == C2_INPUT);
    end

    pport_irq #(.NF(NFLAG)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (flag_set),
        .clr_all  (data_acc),
        .clr_mask (flag_w1c),
        .en       (ien_q),
        .flags    (flags),
        .irq      (irq)
    );

    pport_ctl2 i_ctl2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctrl_q.c2_mode),
        .level    (ctrl_q.c2_pol),
        .data_acc (data_acc),
        .c1_hit   (c1_hit),
        .c2_out   (ctl2_out),
        .c2_oe    (ctl2_oe)
    );

    // Read multiplexer with per-bit merge of outputs and inputs.
    always_comb begin
        in_view   = ctrl_q.c1_latch ? cap_q : pad_in;
        bus_rdata = '0;
        if (bus_cs) begin
            case (bus_addr)
                A_DATA:  bus_rdata = (out_q & dir_q) | (in_view & ~dir_q);
                A_DIR:   bus_rdata = dir_q;
                A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
                A_FLAG:  bus_rdata[NFLAG-1:0]  = flags;
                A_IEN:   bus_rdata[NFLAG-1:0]  = ien_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    // Drive the pin-side outputs from storage.
    always_comb begin
        pad_out = out_q;
        pad_oe  = dir_q;
    end

    // R2: a direction write shows up on the enables one cycle later.
    assert_dir_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

    // R5: a capturing strobe edge stores the pins seen at that edge.
    assert_latch_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.c1_latch && c1_hit) |=> (cap_q == $past(pad_in)));

    // R9: with every enable clear the request stays low.
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/test_hsk_pport.sv
// Scoreboard bench: driver tasks queue expected values, a monitor on the
// falling clock edge pops and compares them against the outputs.
module test_hsk_pport;

    localparam int W = 8;
    localparam int K_RD = 0, K_IRQ = 1, K_C2O = 2, K_C2E = 3, K_PO = 4, K_POE = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe;
    logic         ctl1_in = 1'b0, ctl2_in = 1'b0;
    logic         ctl2_out, ctl2_oe, irq;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    int    q_kind[$];
    logic [W-1:0] q_exp[$];
    string q_tag[$];

    always #10 clk = ~clk;

    hsk_pport #(.WIDTH(W)) i_hsk_pport (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .ctl1_in(ctl1_in), .ctl2_in(ctl2_in),
        .ctl2_out(ctl2_out), .ctl2_oe(ctl2_oe), .irq(irq)
    );

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (q_kind.size() != 0) begin
            automatic int           k   = q_kind.pop_front();
            automatic logic [W-1:0] e   = q_exp.pop_front();
            automatic string        t   = q_tag.pop_front();
            automatic logic [W-1:0] act;
            case (k)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {7'd0, irq};
                K_C2O:   act = {7'd0, ctl2_out};
                K_C2E:   act = {7'd0, ctl2_oe};
                K_PO:    act = pad_out;
                default: act = pad_oe;
            endcase
            n_chk++;
            if (act !== e) begin
                n_err++;
                $display("FAIL %s: actual %02h expected %02h", t, act, e);
            end
        end
    end

    task automatic expect_item(input int k, input logic [W-1:0] e, input string t);
        q_kind.push_back(k);
        q_exp.push_back(e);
        q_tag.push_back(t);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [W-1:0] e, input string t);
        bus_cs = 1'b1; bus_re = 1'b1; bus_addr = a;
        expect_item(K_RD, e, t);
        tick(1);
        bus_cs = 1'b0; bus_re = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Driver: the stimulus sequence, one requirement group at a time.
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        bus_read(3'd0, 8'h00, "R1 data");
        bus_read(3'd1, 8'h00, "R1 dir");
        bus_read(3'd2, 8'h00, "R1 ctrl");
        bus_read(3'd3, 8'h00, "R1 flags");
        bus_read(3'd4, 8'h00, "R1 ien");
        expect_item(K_IRQ, 8'h00, "R1 irq");
        expect_item(K_C2O, 8'h01, "R1 ctl2_out");
        expect_item(K_C2E, 8'h00, "R1 ctl2_oe");
        expect_item(K_POE, 8'h00, "R1 pad_oe");
        tick(1);

        // R2 output data and direction
        bus_write(3'd0, 8'hA5);
        bus_write(3'd1, 8'hF0);
        expect_item(K_PO, 8'hA5, "R2 pad_out");
        expect_item(K_POE, 8'hF0, "R2 pad_oe");
        tick(1);

        // R3 mixed read view
        pad_in = 8'h3C;
        tick(1);
        bus_read(3'd0, 8'hAC, "R3 mixed read");

        // R4 strobe polarity
        bus_write(3'd2, 8'h01);
        ctl1_in = 1'b1; tick(1);
        bus_read(3'd3, 8'h01, "R4 rising edge flag");
        bus_write(3'd3, 8'h01);
        bus_read(3'd3, 8'h00, "R8 w1c clears");
        ctl1_in = 1'b0; tick(1);
        bus_read(3'd3, 8'h00, "R4 falling ignored");
        bus_write(3'd2, 8'h00);
        ctl1_in = 1'b1; tick(1);
        ctl1_in = 1'b0; tick(1);
        bus_read(3'd3, 8'h01, "R4 falling edge flag");

        // R9 enable gating
        bus_write(3'd4, 8'h01);
        expect_item(K_IRQ, 8'h01, "R9 irq enabled");
        tick(1);
        bus_write(3'd4, 8'h02);
        expect_item(K_IRQ, 8'h00, "R9 irq masked");
        tick(1);

        // R7 data read clears flags
        bus_read(3'd0, 8'hAC, "R7 data read");
        bus_read(3'd3, 8'h00, "R7 flags cleared");

        // R8 write zero has no effect
        ctl1_in = 1'b1; tick(1);
        ctl1_in = 1'b0; tick(1);
        bus_write(3'd3, 8'h00);
        bus_read(3'd3, 8'h01, "R8 zero write keeps");
        bus_write(3'd3, 8'h02);
        bus_read(3'd3, 8'h01, "R8 other bit keeps");
        bus_write(3'd3, 8'h01);
        bus_read(3'd3, 8'h00, "R8 own bit clears");

        // R5 capture on strobe edge
        bus_write(3'd2, 8'h03);
        pad_in = 8'h5A;
        ctl1_in = 1'b1; tick(1);
        pad_in = 8'h0F; tick(1);
        bus_read(3'd0, 8'hAA, "R5 captured view");
        bus_write(3'd2, 8'h01);
        bus_read(3'd0, 8'hAF, "R5 live view restored");

        // R6 line 2 as rising-edge input
        bus_write(3'd2, 8'h05);
        ctl2_in = 1'b1; tick(1);
        bus_read(3'd3, 8'h02, "R6 ctl2 flag");
        bus_write(3'd4, 8'h02);
        expect_item(K_IRQ, 8'h01, "R9 ctl2 irq");
        tick(1);
        bus_write(3'd0, 8'hA5);
        expect_item(K_IRQ, 8'h00, "R7 write clears irq");
        tick(1);

        // R7 edge and clear in the same cycle: set wins
        ctl2_in = 1'b0; tick(1);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hA5;
        ctl2_in = 1'b1;
        tick(1);
        bus_cs = 1'b0; bus_we = 1'b0;
        bus_read(3'd3, 8'h02, "R7 set beats clear");
        bus_write(3'd3, 8'h03);
        bus_write(3'd4, 8'h00);

        // R13 line 2 edges ignored in handshake mode
        bus_write(3'd2, 8'h09);
        ctl2_in = 1'b0; tick(1);
        ctl2_in = 1'b1; tick(1);
        bus_read(3'd3, 8'h00, "R13 no ctl2 flag");

        // R10 interlocked handshake
        expect_item(K_C2E, 8'h01, "R12 oe in handshake");
        expect_item(K_C2O, 8'h01, "R10 idle high");
        tick(1);
        bus_write(3'd0, 8'hA5);
        expect_item(K_C2O, 8'h00, "R10 low after write");
        tick(2);
        expect_item(K_C2O, 8'h00, "R10 holds low");
        ctl1_in = 1'b0; tick(1);
        expect_item(K_C2O, 8'h00, "R10 wrong edge holds");
        ctl1_in = 1'b1; tick(1);
        expect_item(K_C2O, 8'h01, "R10 released by strobe");
        tick(1);
        bus_read(3'd0, 8'hAF, "R10 read access");
        expect_item(K_C2O, 8'h00, "R10 low after read");
        ctl1_in = 1'b0; tick(1);
        ctl1_in = 1'b1; tick(1);
        expect_item(K_C2O, 8'h01, "R10 released again");
        tick(1);

        // R11 pulse handshake
        bus_write(3'd2, 8'h11);
        bus_write(3'd0, 8'h5A);
        expect_item(K_C2O, 8'h00, "R11 pulse low");
        tick(1);
        expect_item(K_C2O, 8'h01, "R11 pulse over");
        tick(1);

        // R12 static level
        bus_write(3'd2, 8'h18);
        expect_item(K_C2O, 8'h00, "R12 level low");
        expect_item(K_C2E, 8'h01, "R12 level oe");
        tick(1);
        bus_write(3'd2, 8'h1C);
        expect_item(K_C2O, 8'h01, "R12 level high");
        tick(1);
        bus_write(3'd0, 8'hA5);
        expect_item(K_C2O, 8'h01, "R12 access ignored");
        tick(1);
        bus_write(3'd2, 8'h00);
        expect_item(K_C2E, 8'h00, "R12 input mode oe off");
        tick(1);

        // R3 and R2 with the direction mask inverted
        bus_write(3'd1, 8'h0F);
        pad_in = 8'h3C; tick(1);
        bus_read(3'd0, 8'h35, "R3 inverted mask");
        expect_item(K_POE, 8'h0F, "R2 pad_oe update");
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule